// File: doc/BRIEF.md
# Card Presence Debounce and Interrupt

This block turns the raw card-detect switch of a smart card connector into a clean, debounced card-present flag for the interface sequencer, and drives the level interrupt line read by the host controller. A parameter picks the switch polarity, so the same block serves connectors whose switch closes on insertion and connectors whose switch opens on insertion. After the presence pin is resynchronised, an insertion must hold steady for a full debounce window before it counts. A removal counts at once and raises a one-cycle deactivation request.

The interrupt is a level that is high only when a debounced card is present, the supply is above its undervoltage threshold, and no fault has been seen during the current session. A fault seen during a session is latched. It keeps the interrupt low and also requests a deactivation. The latch is released only once the sequencer reports that the session has ended, meaning the host has withdrawn its command and deactivation is complete. After reset, a power-on hold interval keeps the block inactive whatever the pin does.

Top module: `card_detect_irq`

## Requirements
- R1: With `PRES_ACTIVE_LOW`=1 a low level on `pres_pin` means card present; with `PRES_ACTIVE_LOW`=0 a high level means card present.
- R2: After the pin changes to the present level and stays there, `card_present` goes high exactly `DEBOUNCE_CYCLES`+`SYNC_STAGES`+1 clock edges after the change, and not earlier.
- R3: Any return of the synchronised input to the absent level during the debounce window restarts the window, so the full delay of R2 is counted again from the last change.
- R4: When the pin leaves the present level, `card_present` falls `SYNC_STAGES`+1 edges after the change, with no debounce.
- R5: A removal of a debounced card makes `deact_req` high for exactly one cycle, in the same cycle that `card_present` falls.
- R6: `host_int` is registered: one edge after the inputs settle it equals card present AND NOT undervoltage AND NOT (fault latched or fault seen in session). It is low when no card is present.
- R7: `uv_flag` high drives `host_int` low on the next edge while `card_present` stays high; once `uv_flag` clears with the card still present, `host_int` is high again on the next edge.
- R8: `fault_flag` high while `sess_active` is high drives `host_int` low on the next edge, latches the fault, and gives a one-cycle `deact_req` pulse on the first such cycle.
- R9: A latched fault holds `host_int` low after `fault_flag` clears, until `sess_active` goes low; `fault_flag` while `sess_active` is low is ignored.
- R10: For `POR_CYCLES` edges after reset is released, `card_present` and `host_int` stay low even with a card inserted; debouncing starts only afterwards.
- R11: During reset `card_present`, `host_int` and `deact_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| pres_pin | input | 1 | Raw card-detect switch level, asynchronous |
| uv_flag | input | 1 | Supply below undervoltage threshold, synchronous |
| sess_active | input | 1 | Card session running, held until deactivation completes |
| fault_flag | input | 1 | Overload or overheat detected, synchronous |
| card_present | output | 1 | Debounced card-present flag to the sequencer |
| host_int | output | 1 | Host interrupt level, low means attention |
| deact_req | output | 1 | One-cycle request to run the deactivation sequence |

## Verification
The assertions assume that `uv_flag`, `sess_active` and `fault_flag` come from synchronous logic in the same clock domain. They also assume that `sess_active` falls only after deactivation is done, and that reset is asserted from the first clock edge. Only `pres_pin` may change at any time. The stimulus drives every input one nanosecond after a rising edge and holds reset from time zero. Faults are raised only with a card present, so each check isolates one cause of a low interrupt.

// File: rtl/card_detect_pkg.sv
`timescale 1ns/1ps
package card_detect_pkg;

    typedef enum logic [1:0] {
        DB_ABSENT  = 2'd0,
        DB_WAIT    = 2'd1,
        DB_PRESENT = 2'd2
    } db_state_e;

    typedef struct packed {
        logic uv;
        logic sess;
        logic fault;
    } irq_cond_t;

    // Map the raw switch level to "card present" for the chosen polarity.
    function automatic logic pin_to_present(input logic pin, input bit active_low);
        return active_low ? ~pin : pin;
    endfunction

endpackage

// File: rtl/cd_sync.sv
`timescale 1ns/1ps
module cd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] stage_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[0] <= 1'b0;
                    else     stage_q[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[i] <= 1'b0;
                    else     stage_q[i] <= stage_q[i-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/cd_por_hold.sv
`timescale 1ns/1ps
module cd_por_hold #(
    parameter int POR_CYCLES = 80000
) (
    input  logic clk,
    input  logic rst,
    output logic busy
);
    localparam int CW = $clog2(POR_CYCLES + 1);

    logic [CW-1:0] cnt_q;
    logic          busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            busy_q <= 1'b1;
        end else if (busy_q) begin
            if (cnt_q == CW'(POR_CYCLES - 1)) busy_q <= 1'b0;
            else                              cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign busy = busy_q;

    assert_hold_bound_R10: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (cnt_q < CW'(POR_CYCLES)));
    assert_hold_ends_R10: assert property (@(posedge clk) disable iff (rst)
        !busy_q |=> !busy_q);
endmodule

// File: rtl/cd_debounce.sv
`timescale 1ns/1ps
module cd_debounce
    import card_detect_pkg::*;
#(
    parameter int DEBOUNCE_CYCLES = 80000
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic present_s,
    output logic present,
    output logic removed
);
    localparam int CW = $clog2(DEBOUNCE_CYCLES + 1);

    db_state_e     state_q;
    logic [CW-1:0] cnt_q;
    logic          removed_q;

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            state_q   <= DB_ABSENT;
            cnt_q     <= '0;
            removed_q <= 1'b0;
        end else begin
            removed_q <= 1'b0;
            unique case (state_q)
                DB_ABSENT: begin
                    cnt_q <= '0;
                    if (present_s) state_q <= DB_WAIT;
                end
                DB_WAIT: begin
                    if (!present_s) begin
                        state_q <= DB_ABSENT;
                        cnt_q   <= '0;
                    end else if (cnt_q == CW'(DEBOUNCE_CYCLES - 1)) begin
                        state_q <= DB_PRESENT;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                DB_PRESENT: begin
                    if (!present_s) begin
                        state_q   <= DB_ABSENT;
                        cnt_q     <= '0;
                        removed_q <= 1'b1;
                    end
                end
                default: state_q <= DB_ABSENT;
            endcase
        end
    end

    assign present = (state_q == DB_PRESENT);
    assign removed = removed_q;

    assert_insert_needs_input_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(present) |-> $past(present_s));
    assert_window_bound_R3: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CW'(DEBOUNCE_CYCLES));
    assert_removal_fast_R4: assert property (@(posedge clk) disable iff (rst)
        (present && !present_s) |=> !present);
    assert_removal_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(present) && !$past(hold) |-> removed);
    assert_hold_blocks_R10: assert property (@(posedge clk) disable iff (rst)
        hold |=> !present);
endmodule

// File: rtl/cd_irq_logic.sv
`timescale 1ns/1ps
module cd_irq_logic
    import card_detect_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      card_present,
    input  irq_cond_t cond,
    output logic      host_int,
    output logic      fault_trip
);
    logic fault_lat_q;
    logic trip_q;
    logic int_q;
    logic fault_now;

    assign fault_now = cond.sess && cond.fault;

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_lat_q <= 1'b0;
            trip_q      <= 1'b0;
            int_q       <= 1'b0;
        end else begin
            if (!cond.sess)     fault_lat_q <= 1'b0;
            else if (fault_now) fault_lat_q <= 1'b1;
            trip_q <= fault_now && !fault_lat_q;
            int_q  <= card_present && !cond.uv && !fault_lat_q && !fault_now;
        end
    end

    assign host_int   = int_q;
    assign fault_trip = trip_q;

    assert_int_needs_card_R6: assert property (@(posedge clk) disable iff (rst)
        int_q |-> $past(card_present));
    assert_uv_lowers_int_R7: assert property (@(posedge clk) disable iff (rst)
        cond.uv |=> !int_q);
    assert_fault_lowers_int_R8: assert property (@(posedge clk) disable iff (rst)
        fault_now |=> (!int_q && fault_lat_q));
    assert_latch_needs_session_R9: assert property (@(posedge clk) disable iff (rst)
        !cond.sess |=> !fault_lat_q);
endmodule

// File: rtl/card_detect_irq.sv
`timescale 1ns/1ps
module card_detect_irq
    import card_detect_pkg::*;
#(
    parameter bit PRES_ACTIVE_LOW = 1'b1,
    parameter int SYNC_STAGES     = 2,
    parameter int DEBOUNCE_CYCLES = 80000,
    parameter int POR_CYCLES      = 80000
) (
    input  logic clk,
    input  logic rst,
    input  logic pres_pin,
    input  logic uv_flag,
    input  logic sess_active,
    input  logic fault_flag,
    output logic card_present,
    output logic host_int,
    output logic deact_req
);
    logic      present_raw;
    logic      present_s;
    logic      por_busy;
    logic      removed;
    logic      fault_trip;
    irq_cond_t cond;

    assign present_raw = pin_to_present(pres_pin, PRES_ACTIVE_LOW);

    cd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (present_raw),
        .q   (present_s)
    );

    cd_por_hold #(.POR_CYCLES(POR_CYCLES)) u_por (
        .clk  (clk),
        .rst  (rst),
        .busy (por_busy)
    );

    cd_debounce #(.DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) u_deb (
        .clk       (clk),
        .rst       (rst),
        .hold      (por_busy),
        .present_s (present_s),
        .present   (card_present),
        .removed   (removed)
    );

    assign cond = '{uv: uv_flag, sess: sess_active, fault: fault_flag};

    cd_irq_logic u_irq (
        .clk          (clk),
        .rst          (rst),
        .card_present (card_present),
        .cond         (cond),
        .host_int     (host_int),
        .fault_trip   (fault_trip)
    );

    assign deact_req = removed || fault_trip;

    assert_por_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        por_busy |-> (!card_present && !host_int));
    assert_req_has_cause_R5: assert property (@(posedge clk) disable iff (rst)
        deact_req |-> ($fell(card_present) || $past(sess_active && fault_flag)));
endmodule

// File: tb/sim_card_detect_irq.sv
`timescale 1ns/1ps
module sim_card_detect_irq;
    localparam int SYNC = 2;
    localparam int DEB  = 20;
    localparam int POR  = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pin_lo = 1'b1;   // active-low part: 1 = absent
    logic pin_hi = 1'b0;   // active-high part: 0 = absent
    logic uv = 1'b0, sess = 1'b0, fault = 1'b0;
    logic pres0, int0, req0, pres1, int1, req1;
    int   n_run = 0, n_fail = 0;
    bit   done = 0;

    always #2 clk = ~clk;

    card_detect_irq #(.PRES_ACTIVE_LOW(1'b1), .SYNC_STAGES(SYNC),
        .DEBOUNCE_CYCLES(DEB), .POR_CYCLES(POR)) u0 (
        .clk(clk), .rst(rst), .pres_pin(pin_lo), .uv_flag(uv),
        .sess_active(sess), .fault_flag(fault),
        .card_present(pres0), .host_int(int0), .deact_req(req0));

    card_detect_irq #(.PRES_ACTIVE_LOW(1'b0), .SYNC_STAGES(SYNC),
        .DEBOUNCE_CYCLES(DEB), .POR_CYCLES(POR)) u1 (
        .clk(clk), .rst(rst), .pres_pin(pin_hi), .uv_flag(uv),
        .sess_active(1'b0), .fault_flag(1'b0),
        .card_present(pres1), .host_int(int1), .deact_req(req1));

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic t_reset_and_por();
        tick(2);
        check("R11", "present in reset", pres0, 1'b0);
        check("R11", "int in reset", int0, 1'b0);
        check("R11", "deact in reset", req0, 1'b0);
        pin_lo = 1'b0;           // card already inserted at power-up
        tick(1);
        rst = 1'b0;
        tick(POR);
        check("R10", "present held at end of hold", pres0, 1'b0);
        check("R10", "int held at end of hold", int0, 1'b0);
        tick(DEB);
        check("R10", "debounce starts after hold", pres0, 1'b0);
        tick(1);
        check("R10", "present after hold+debounce", pres0, 1'b1);
        tick(1);
        check("R6", "int high with card", int0, 1'b1);
        check("R1", "active-high part sees absent", pres1, 1'b0);
    endtask

    task automatic t_removal();
        pin_lo = 1'b1;
        tick(SYNC);
        check("R4", "present before sync latency", pres0, 1'b1);
        tick(1);
        check("R4", "present dropped", pres0, 1'b0);
        check("R5", "deact pulse", req0, 1'b1);
        tick(1);
        check("R5", "deact pulse one cycle", req0, 1'b0);
        check("R6", "int low without card", int0, 1'b0);
    endtask

    task automatic t_insert();
        pin_lo = 1'b0;
        pin_hi = 1'b1;
        tick(DEB + SYNC);
        check("R2", "not present early", pres0, 1'b0);
        check("R1", "active-high not present early", pres1, 1'b0);
        tick(1);
        check("R2", "present on time", pres0, 1'b1);
        check("R1", "active-high present on time", pres1, 1'b1);
        tick(1);
        check("R1", "active-high int", int1, 1'b1);
    endtask

    task automatic t_bounce();
        pin_lo = 1'b1;
        tick(6);
        pin_lo = 1'b0;
        tick(10);
        pin_lo = 1'b1;           // one-cycle bounce inside the window
        tick(1);
        pin_lo = 1'b0;
        tick(DEB + SYNC);
        check("R3", "window restarted", pres0, 1'b0);
        tick(1);
        check("R3", "present after restarted window", pres0, 1'b1);
        tick(1);
    endtask

    task automatic t_uv();
        uv = 1'b1;
        tick(1);
        check("R7", "int low on uv", int0, 1'b0);
        check("R7", "card still present on uv", pres0, 1'b1);
        uv = 1'b0;
        tick(1);
        check("R7", "int back after uv", int0, 1'b1);
    endtask

    task automatic t_fault();
        fault = 1'b1;            // outside a session
        tick(2);
        check("R9", "fault ignored without session", int0, 1'b1);
        check("R9", "no deact without session", req0, 1'b0);
        fault = 1'b0;
        sess = 1'b1;
        tick(2);
        check("R6", "int high in clean session", int0, 1'b1);
        fault = 1'b1;
        tick(1);
        check("R8", "int low on fault", int0, 1'b0);
        check("R8", "deact on fault", req0, 1'b1);
        fault = 1'b0;
        tick(1);
        check("R8", "deact one cycle", req0, 1'b0);
        tick(3);
        check("R9", "fault stays latched", int0, 1'b0);
        sess = 1'b0;
        tick(1);
        check("R9", "latch clearing takes a cycle", int0, 1'b0);
        tick(1);
        check("R9", "int back after session end", int0, 1'b1);
    endtask

    initial begin
        t_reset_and_por();
        t_removal();
        t_insert();
        t_bounce();
        t_uv();
        t_fault();
        t_removal();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #20000;
        if (!done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule